// File: doc/BRIEF.md
# Bus Error Capture Register

This block sits beside a memory and bus controller and records the first bus fault it is told about. A fault is reported by a one-cycle strobe that comes with four attributes: which agent owned the transfer (processor or DMA), its direction, whether the fault was an ECC failure, and the word address involved. Once a fault is held, the block raises a level interrupt. Later faults do not change what is held until software acknowledges the fault.

Without the ECC flag, a processor fault means the transfer timed out and a DMA fault means an overrun. With the ECC flag, a read-flagged fault is a failed memory read and a write-flagged fault is a failed partial memory write. Reads reach the memory through a pipeline, so for an ECC read the held page offset is ahead of the faulting word by the pipeline depth. The page offset is the low bits of the word address. Software gets the true word address by subtracting the depth inside the page, and the byte address is that word address shifted left by two.

Software reads the captured word over a simple select/write-enable register port. A write with any data acknowledges the fault, so the data lines do not need to reach this block.

Top module: `errcap_unit`

## Requirements
- R1: After reset, the interrupt is low and a read returns all zeros.
- R2: A fault strobe while nothing is held is stored on the next clock edge. The read word is laid out as bit 31 valid (1), bit 30 agent (1 = processor, 0 = DMA), bit 29 direction (1 = write, 0 = read), bit 28 ECC flag, and bits 27:0 word address.
- R3: The interrupt is level-high and always equals the valid bit of the read word.
- R4: While a fault is held, further fault strobes do not change the read word.
- R5: Any register write clears the held word and the interrupt on the next clock edge. After that, a new fault can be captured.
- R6: A fault strobe in the same cycle as a register write is dropped, and the word reads zero afterwards.
- R7: For an ECC read fault, the stored address has its low 12 bits raised by 5, wrapping within those 12 bits. The upper address bits are stored unchanged.
- R8: For non-ECC faults and for ECC write faults, the stored address equals the reported address.
- R9: The read word is all zeros whenever the register is not selected for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | One-cycle fault strobe |
| evt_cpu | input | 1 | Agent of the fault: 1 processor, 0 DMA |
| evt_write | input | 1 | Direction of the fault: 1 write, 0 read |
| evt_ecc | input | 1 | Fault is an ECC failure |
| evt_addr | input | 28 | Word address of the fault |
| bus_sel | input | 1 | Register select |
| bus_we | input | 1 | Write enable; a selected write acknowledges |
| bus_rdata | output | 32 | Read word, zero when not read-selected |
| irq | output | 1 | Level interrupt, high while a fault is held |

## Verification
A corrupted valid bit shows up one edge after the strobe or the acknowledge. It appears as a wrong interrupt level and a wrong bit 31 in the next read. A broken hold or clear path shows up on the first read after a second strobe, because the word no longer matches the first fault. A wrong skew, wrap or field position shows up in the address and flag bits of the very next read after an ECC capture. Reads are placed one cycle after each stimulus, so any such fault is seen within two cycles.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
   localparam int FLAG_W = 4;

   typedef struct packed {
      logic valid;
      logic cpu;
      logic wr;
      logic ecc;
   } errcap_flags_t;
endpackage

// File: rtl/errcap_skew.sv
module errcap_skew #(
   parameter int ADDR_W    = 28,
   parameter int PAGE_BITS = 12,
   parameter int PIPE_SKEW = 5,
   parameter bit SKEW_EN   = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              is_ecc,
   input  logic              is_wr,
   output logic [ADDR_W-1:0] addr_out
);
   localparam logic [PAGE_BITS-1:0] SKEW_V = PAGE_BITS'(PIPE_SKEW);

   generate
      if (!SKEW_EN) begin : g_flat
         logic unused_ok;
         assign unused_ok = is_ecc ^ is_wr;
         assign addr_out  = addr_in;
      end else if (PAGE_BITS == ADDR_W) begin : g_full
         always_comb begin
            addr_out = addr_in;
            if (is_ecc && !is_wr) addr_out = addr_in + SKEW_V;
         end
      end else begin : g_page
         logic [PAGE_BITS-1:0] low_adj;
         always_comb begin
            low_adj = addr_in[PAGE_BITS-1:0];
            if (is_ecc && !is_wr) low_adj = addr_in[PAGE_BITS-1:0] + SKEW_V;
         end
         assign addr_out = {addr_in[ADDR_W-1:PAGE_BITS], low_adj};
      end
   endgenerate
endmodule

// File: rtl/errcap_ctrl.sv
module errcap_ctrl (
   input  logic evt_valid,
   input  logic held,
   input  logic bus_sel,
   input  logic bus_we,
   output logic load,
   output logic clear
);
   always_comb begin
      clear = bus_sel && bus_we;
      load  = evt_valid && !held && !clear;
   end
endmodule

// File: rtl/errcap_store.sv
module errcap_store #(
   parameter int ADDR_W = 28
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic                    clear,
   input  errcap_pkg::errcap_flags_t flags_in,
   input  logic [ADDR_W-1:0]       addr_in,
   output errcap_pkg::errcap_flags_t flags_q,
   output logic [ADDR_W-1:0]       addr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         addr_q  <= '0;
      end else if (clear) begin
         flags_q <= '0;
         addr_q  <= '0;
      end else if (load) begin
         flags_q <= flags_in;
         addr_q  <= addr_in;
      end
   end
endmodule

// File: rtl/errcap_unit.sv
module errcap_unit #(
   parameter int ADDR_W    = 28,
   parameter int PAGE_BITS = 12,
   parameter int PIPE_SKEW = 5,
   parameter bit SKEW_EN   = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  evt_valid,
   input  logic                                  evt_cpu,
   input  logic                                  evt_write,
   input  logic                                  evt_ecc,
   input  logic [ADDR_W-1:0]                     evt_addr,
   input  logic                                  bus_sel,
   input  logic                                  bus_we,
   output logic [ADDR_W+errcap_pkg::FLAG_W-1:0]  bus_rdata,
   output logic                                  irq
);
   import errcap_pkg::*;
   localparam int DATA_W = ADDR_W + FLAG_W;

   generate
      if (PAGE_BITS < 1 || PAGE_BITS > ADDR_W) begin : g_bad_page
         $error("errcap_unit: PAGE_BITS out of range");
      end
      if (PIPE_SKEW < 0 || PIPE_SKEW >= (1 << PAGE_BITS)) begin : g_bad_skew
         $error("errcap_unit: PIPE_SKEW does not fit the page");
      end
   endgenerate

   errcap_flags_t     flags_in, flags_q;
   logic [ADDR_W-1:0] addr_adj, addr_q;
   logic              load, clear;
   logic [DATA_W-1:0] cap_word;

   assign flags_in = '{valid: 1'b1, cpu: evt_cpu, wr: evt_write, ecc: evt_ecc};

   errcap_skew #(
      .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
      .PIPE_SKEW(PIPE_SKEW), .SKEW_EN(SKEW_EN)
   ) u_skew (
      .addr_in(evt_addr), .is_ecc(evt_ecc), .is_wr(evt_write), .addr_out(addr_adj)
   );

   errcap_ctrl u_ctrl (
      .evt_valid(evt_valid), .held(flags_q.valid),
      .bus_sel(bus_sel), .bus_we(bus_we), .load(load), .clear(clear)
   );

   errcap_store #(.ADDR_W(ADDR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .load(load), .clear(clear),
      .flags_in(flags_in), .addr_in(addr_adj),
      .flags_q(flags_q), .addr_q(addr_q)
   );

   assign cap_word  = {flags_q, addr_q};
   assign bus_rdata = (bus_sel && !bus_we) ? cap_word : '0;
   assign irq       = flags_q.valid;
endmodule

// File: rtl/errcap_chk.sv
module errcap_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_valid,
   input logic              bus_sel,
   input logic              bus_we,
   input logic              irq,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [DATA_W-1:0] cap_word
);
   assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && evt_valid && !(bus_sel && bus_we)) |=> irq);

   assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !evt_valid) |=> !irq);

   assert_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we) |-> (bus_rdata[DATA_W-1] == irq));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(bus_sel && bus_we)) |=> (irq && $stable(cap_word)));

   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we) |=> !irq);

   assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && evt_valid) |=> (cap_word == '0));

   assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> (bus_rdata == '0));
endmodule

bind errcap_unit errcap_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .bus_sel(bus_sel),
   .bus_we(bus_we), .irq(irq), .bus_rdata(bus_rdata), .cap_word(cap_word)
);

// File: tb/errcap_unit_bench.sv
module errcap_unit_bench;
   localparam int AW = 28;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evt_valid = 1'b0, evt_cpu = 1'b0, evt_write = 1'b0, evt_ecc = 1'b0;
   logic [AW-1:0] evt_addr = '0;
   logic          bus_sel = 1'b0, bus_we = 1'b0;
   logic [DW-1:0] bus_rdata;
   logic          irq;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [DW-1:0] exp_q[$];
   string         tag_q[$];

   always #2 clk = ~clk;

   errcap_unit u_errcap_unit (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_cpu(evt_cpu),
      .evt_write(evt_write), .evt_ecc(evt_ecc), .evt_addr(evt_addr),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [DW-1:0] model(input bit cpu, input bit wr,
                                            input bit ecc, input logic [AW-1:0] a);
      logic [AW-1:0] s;
      s = a;
      if (ecc && !wr) s[11:0] = a[11:0] + 12'd5;
      return {1'b1, cpu, wr, ecc, s};
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk); #1;
      evt_valid = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic fire(input bit cpu, input bit wr, input bit ecc, input logic [AW-1:0] a);
      @(posedge clk); #1;
      evt_valid = 1'b1; evt_cpu = cpu; evt_write = wr; evt_ecc = ecc; evt_addr = a;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic ack(input bit with_evt);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_we = 1'b1; evt_valid = with_evt;
      evt_cpu = 1'b1; evt_write = 1'b0; evt_ecc = 1'b0; evt_addr = 28'h0AA_0055;
   endtask

   task automatic rd(input logic [DW-1:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(posedge clk); #1;
      evt_valid = 1'b0; bus_sel = 1'b1; bus_we = 1'b0;
   endtask

   // monitor: pops expected read words as the design presents them
   always @(negedge clk) begin
      if (rst_n && bus_sel && !bus_we && exp_q.size() > 0) begin
         logic [DW-1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, bus_rdata, e);
         check({t, "/R3 irq"}, {31'd0, irq}, {31'd0, e[DW-1]});
      end
   end

   initial begin
      logic [DW-1:0] w;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 irq after reset", {31'd0, irq}, 32'd0);
      rd(32'd0, "R1 reset word");

      fire(1'b1, 1'b0, 1'b0, 28'h123_4567);
      w = model(1'b1, 1'b0, 1'b0, 28'h123_4567);
      rd(w, "R2 cpu read timeout");
      step(); @(negedge clk);
      check("R9 unselected read", bus_rdata, 32'd0);
      check("R3 irq held", {31'd0, irq}, 32'd1);

      fire(1'b0, 1'b1, 1'b1, 28'h0FF_FFF0);
      rd(w, "R4 second fault ignored");

      ack(1'b0);
      rd(32'd0, "R5 cleared by write");

      fire(1'b0, 1'b1, 1'b0, 28'h876_5432);
      rd(model(1'b0, 1'b1, 1'b0, 28'h876_5432), "R5 recapture / R8 dma write overrun");
      ack(1'b0);

      fire(1'b1, 1'b0, 1'b1, 28'hABC_DFFD);
      rd(28'hABC_D002 | 32'hD000_0000, "R7 ecc read wrap");
      ack(1'b0);

      fire(1'b0, 1'b0, 1'b1, 28'h000_0FFF);
      rd(model(1'b0, 1'b0, 1'b1, 28'h000_0FFF), "R7 ecc dma read page top");
      ack(1'b0);

      fire(1'b1, 1'b0, 1'b1, 28'h100_0000);
      rd(32'hD100_0005, "R7 ecc read low page");
      ack(1'b0);

      fire(1'b0, 1'b1, 1'b1, 28'h555_5FFE);
      rd(model(1'b0, 1'b1, 1'b1, 28'h555_5FFE), "R8 ecc partial write unchanged");

      ack(1'b1);
      rd(32'd0, "R6 clear beats event");
      step(); @(negedge clk);
      check("R6 irq low after clash", {31'd0, irq}, 32'd0);

      fire(1'b0, 1'b0, 1'b0, 28'hFFF_FFFF);
      rd(model(1'b0, 1'b0, 1'b0, 28'hFFF_FFFF), "R2 dma read overrun all ones");
      step(); step();

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule